// File: doc/BRIEF.md
# Flash Array Operation Scheduler

This block sits behind the command decoder of a serial flash with two page buffers. Each cycle it can receive one decoded command: an opcode byte and a page address. It decides at once whether that command may start. Commands fall into three kinds. Array commands occupy the flash array for a self-timed interval. Buffer commands only touch one of the two buffers. Status reads touch neither.

Only one array operation runs at a time. While it runs, the array is held, together with the buffer that the opcode selects. Buffer traffic to the other buffer, and status reads, are still admitted. This lets a host fill one buffer while the other one is being programmed.

The length of an array operation comes from a loadable cycle count per operation class, which stands in for the real array timing. The scheduler drives a busy bit and a pull-low enable for an open-drain ready/busy pin. It also refuses program and erase commands aimed at the low pages while write protection is active, keeps a sticky error flag for every refusal, and returns to idle on reset.

Top module: `fls_op_scheduler`

## Requirements
- R1: An array command (opcodes 52h, D2h, 53h, 55h, 60h, 61h, 83h, 86h, 88h, 89h, 82h, 85h, 58h, 59h, 81h, 50h) is refused while `array_held` is 1, so at most one array operation is in progress.
- R2: Buffer commands are admitted during an array operation unless they target the held buffer. Buffer-1 commands are 54h, D4h and 84h; buffer-2 commands are 56h, D6h and 87h. Status reads (57h, D7h) are always admitted.
- R3: `held_buf` shows the buffer an array operation holds: 2'b01 for buffer 1 (53h, 60h, 83h, 88h, 82h, 58h), 2'b10 for buffer 2 (55h, 61h, 86h, 89h, 85h, 59h), and 2'b00 for page read and erase (52h, D2h, 81h, 50h) or when idle.
- R4: `busy` and `rdy_pull_low` are 1 exactly while a transfer, compare, program or erase operation holds the array. A page read (52h, D2h) holds the array with `busy` at 0.
- R5: With `wp_n` at 0, program and erase opcodes (83h, 86h, 88h, 89h, 82h, 85h, 58h, 59h, 81h, 50h) whose page is below 256 are refused. With `wp_n` at 1, or with page 256 or above, they are admitted. Page read, transfer and compare are never refused by protection.
- R6: Any opcode outside the sets in R1 and R2, for example 12h or E8h, is refused.
- R7: A command presented with `cmd_valid` high in cycle N produces exactly one of `cmd_accept` or `cmd_reject` as a one-cycle pulse in cycle N+1. `start_array` or `start_buffer` pulses in that same cycle for accepted array or buffer commands.
- R8: An accepted array operation with duration D holds the array for exactly D cycles, beginning in the accept cycle. `op_done` pulses once, in the last of those cycles. A duration of 0 behaves as 1.
- R9: Writing a duration (`dur_we`, with `dur_sel` 0 = read, 1 = transfer/compare, 2 = program, 3 = erase) affects only operations that start later and only that class.
- R10: While `rst_n` is 0 the block is idle: no accept or reject pulses, `array_held` at 0, `err_flag` cleared, and all durations back to their parameter defaults.
- R11: `err_flag` is 0 after reset, sets on any refusal, and stays set until reset.
- R12: An array command presented in the cycle where `op_done` is 1 is refused, and `array_held` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; aborts any operation |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_page | input | PAGE_W | Target page address |
| wp_n | input | 1 | Write protect, active low |
| dur_we | input | 1 | Load a duration value |
| dur_sel | input | 2 | Operation class whose duration is loaded |
| dur_val | input | CNT_W | Duration in cycles |
| cmd_accept | output | 1 | Command admitted (pulse) |
| cmd_reject | output | 1 | Command refused (pulse) |
| start_array | output | 1 | Array operation starts (pulse) |
| start_buffer | output | 1 | Buffer access starts (pulse) |
| array_held | output | 1 | An array operation is in progress |
| busy | output | 1 | Busy status bit |
| rdy_pull_low | output | 1 | Drive-low enable for the ready/busy pin |
| err_flag | output | 1 | Sticky refusal flag |
| held_buf | output | 2 | Buffer held by the array operation |
| op_done | output | 1 | Last cycle of the array operation |

## Verification
The assertions assume that every input is known and changes only between clock edges. They also assume the duration timer only ever receives a start while it is idle, which the admission logic guarantees. The bench drives all inputs on the falling edge and samples on the next falling edge. Before each stimulus vector that needs an idle array, it waits for `array_held` to fall. It sets every duration to 30 cycles before the vector walk, so that the vectors issued while an operation is held all fall inside that operation.

// File: rtl/fls_sched_pkg.sv
`timescale 1ns/1ps
// Shared types for the flash operation scheduler.
// Assumes: an operation class indexes the duration table directly.
package fls_sched_pkg;

    localparam int NUM_CLASS = 4;

    typedef enum logic [1:0] {
        CLS_READ  = 2'd0,
        CLS_XFER  = 2'd1,
        CLS_PROG  = 2'd2,
        CLS_ERASE = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        GRP_NONE   = 2'd0,
        GRP_ARRAY  = 2'd1,
        GRP_BUFFER = 2'd2,
        GRP_STATUS = 2'd3
    } cmd_group_e;

    typedef struct packed {
        cmd_group_e grp;
        op_class_e  cls;
        logic [1:0] bufsel;   // one-hot buffer touched or held, 0 = none
        logic       guarded;  // subject to low-page write protection
    } cmd_info_t;

endpackage

// File: rtl/fls_cmd_decode.sv
`timescale 1ns/1ps
// Opcode classifier: maps an opcode byte to its group, operation class,
// buffer selection and protection flag.
// Assumes: unlisted opcodes are illegal and yield GRP_NONE.
module fls_cmd_decode
    import fls_sched_pkg::*;
(
    input  logic [7:0] op,
    output cmd_info_t  info
);

    // Purpose: table lookup of command attributes.
    always_comb begin
        info = '{grp: GRP_NONE, cls: CLS_READ, bufsel: 2'b00, guarded: 1'b0};
        case (op)
            8'h52, 8'hD2: info = '{GRP_ARRAY, CLS_READ, 2'b00, 1'b0};
            8'h53, 8'h60: info = '{GRP_ARRAY, CLS_XFER, 2'b01, 1'b0};
            8'h55, 8'h61: info = '{GRP_ARRAY, CLS_XFER, 2'b10, 1'b0};
            8'h83, 8'h88,
            8'h82, 8'h58: info = '{GRP_ARRAY, CLS_PROG, 2'b01, 1'b1};
            8'h86, 8'h89,
            8'h85, 8'h59: info = '{GRP_ARRAY, CLS_PROG, 2'b10, 1'b1};
            8'h81, 8'h50: info = '{GRP_ARRAY, CLS_ERASE, 2'b00, 1'b1};
            8'h54, 8'hD4,
            8'h84:        info = '{GRP_BUFFER, CLS_READ, 2'b01, 1'b0};
            8'h56, 8'hD6,
            8'h87:        info = '{GRP_BUFFER, CLS_READ, 2'b10, 1'b0};
            8'h57, 8'hD7: info = '{GRP_STATUS, CLS_READ, 2'b00, 1'b0};
            default:      info = '{GRP_NONE, CLS_READ, 2'b00, 1'b0};
        endcase
    end

endmodule

// File: rtl/fls_admit.sv
`timescale 1ns/1ps
// Admission check: decides in the same cycle whether a decoded command may
// start, given the array state and the buffer held.
// Assumes: held_buf is 0 whenever no array operation is in progress.
module fls_admit
    import fls_sched_pkg::*;
#(
    parameter int PAGE_W     = 11,
    parameter int PROT_PAGES = 256
) (
    input  logic              valid,
    input  cmd_info_t         info,
    input  logic [PAGE_W-1:0] page,
    input  logic              wp_n,
    input  logic              array_held,
    input  logic [1:0]        held_buf,
    output logic              grant,
    output logic              refuse,
    output logic              go_array,
    output logic              go_buffer
);

    localparam logic [PAGE_W:0] PROT_LIM = PROT_PAGES[PAGE_W:0];

    logic prot_hit;
    logic ok;

    // Purpose: flag a program or erase aimed at the protected page range.
    always_comb prot_hit = info.guarded && !wp_n && ({1'b0, page} < PROT_LIM);

    // Purpose: per-group admission rule.
    always_comb begin
        case (info.grp)
            GRP_ARRAY:  ok = !array_held && !prot_hit;
            GRP_BUFFER: ok = ((info.bufsel & held_buf) == 2'b00);
            GRP_STATUS: ok = 1'b1;
            default:    ok = 1'b0;
        endcase
    end

    // Purpose: split the decision into accept, refuse and start requests.
    always_comb begin
        grant     = valid && ok;
        refuse    = valid && !ok;
        go_array  = grant && (info.grp == GRP_ARRAY);
        go_buffer = grant && (info.grp == GRP_BUFFER);
    end

endmodule

// File: rtl/fls_op_timer.sv
`timescale 1ns/1ps
// Self-timed operation model: one loadable duration per class and a
// down-counter that runs one array operation at a time.
// Assumes: start is only raised while the counter is idle.
module fls_op_timer
    import fls_sched_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DUR_READ  = 3,
    parameter int DUR_XFER  = 5,
    parameter int DUR_PROG  = 8,
    parameter int DUR_ERASE = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  op_class_e        cfg_sel,
    input  logic [CNT_W-1:0] cfg_val,
    input  logic             start,
    input  op_class_e        start_cls,
    output logic             running,
    output logic             done
);

    localparam logic [NUM_CLASS-1:0][CNT_W-1:0] DEF_DUR = {
        CNT_W'(DUR_ERASE), CNT_W'(DUR_PROG), CNT_W'(DUR_XFER), CNT_W'(DUR_READ)
    };
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [NUM_CLASS-1:0][CNT_W-1:0] dur_vec;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] sel_dur;
    logic [CNT_W-1:0] load_val;

    genvar g;
    generate
        for (g = 0; g < NUM_CLASS; g++) begin : g_dur
            logic [CNT_W-1:0] dur_r;
            // Purpose: hold the duration of one class, defaults on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dur_r <= DEF_DUR[g];
                else if (cfg_we && (cfg_sel == op_class_e'(g)))
                    dur_r <= cfg_val;
            end
            assign dur_vec[g] = dur_r;
        end
    endgenerate

    // Purpose: pick the duration of the starting class, zero counts as one.
    always_comb begin
        sel_dur  = dur_vec[start_cls];
        load_val = (sel_dur == '0) ? ONE : sel_dur;
    end

    // Purpose: count the running operation down to its last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt_q   <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt_q   <= load_val;
        end else if (running) begin
            if (cnt_q == ONE) begin
                running <= 1'b0;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign done = running && (cnt_q == ONE);

    p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !running);
    p_cnt_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt_q != '0));
    p_start_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !running);

endmodule

// File: rtl/fls_op_scheduler.sv
`timescale 1ns/1ps
// Flash operation scheduler: admits decoded commands, runs one array
// operation at a time, locks the buffer it uses, applies low-page write
// protection and reports busy and a sticky refusal flag.
// Assumes: one command per cycle; reset is synchronous and aborts all work.
module fls_op_scheduler
    import fls_sched_pkg::*;
#(
    parameter int PAGE_W     = 11,
    parameter int CNT_W      = 16,
    parameter int PROT_PAGES = 256,
    parameter int DUR_READ   = 3,
    parameter int DUR_XFER   = 5,
    parameter int DUR_PROG   = 8,
    parameter int DUR_ERASE  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic              wp_n,
    input  logic              dur_we,
    input  logic [1:0]        dur_sel,
    input  logic [CNT_W-1:0]  dur_val,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic              start_array,
    output logic              start_buffer,
    output logic              array_held,
    output logic              busy,
    output logic              rdy_pull_low,
    output logic              err_flag,
    output logic [1:0]        held_buf,
    output logic              op_done
);

    localparam logic [PAGE_W:0] PROT_LIM = PROT_PAGES[PAGE_W:0];

    cmd_info_t info;
    logic      grant, refuse, go_array, go_buffer;
    logic      running, done;
    op_class_e cls_q;

    fls_cmd_decode u_decode (
        .op   (cmd_op),
        .info (info)
    );

    fls_admit #(
        .PAGE_W     (PAGE_W),
        .PROT_PAGES (PROT_PAGES)
    ) u_admit (
        .valid      (cmd_valid),
        .info       (info),
        .page       (cmd_page),
        .wp_n       (wp_n),
        .array_held (running),
        .held_buf   (held_buf),
        .grant      (grant),
        .refuse     (refuse),
        .go_array   (go_array),
        .go_buffer  (go_buffer)
    );

    fls_op_timer #(
        .CNT_W     (CNT_W),
        .DUR_READ  (DUR_READ),
        .DUR_XFER  (DUR_XFER),
        .DUR_PROG  (DUR_PROG),
        .DUR_ERASE (DUR_ERASE)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (dur_we),
        .cfg_sel   (op_class_e'(dur_sel)),
        .cfg_val   (dur_val),
        .start     (go_array),
        .start_cls (info.cls),
        .running   (running),
        .done      (done)
    );

    // Purpose: register the one-cycle response and start strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_accept   <= 1'b0;
            cmd_reject   <= 1'b0;
            start_array  <= 1'b0;
            start_buffer <= 1'b0;
        end else begin
            cmd_accept   <= grant;
            cmd_reject   <= refuse;
            start_array  <= go_array;
            start_buffer <= go_buffer;
        end
    end

    // Purpose: set the sticky error flag on any refusal.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_flag <= 1'b0;
        else if (refuse)
            err_flag <= 1'b1;
    end

    // Purpose: record the buffer and class held by the running operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_buf <= 2'b00;
            cls_q    <= CLS_READ;
        end else if (go_array) begin
            held_buf <= info.bufsel;
            cls_q    <= info.cls;
        end else if (done) begin
            held_buf <= 2'b00;
        end
    end

    assign array_held   = running;
    assign op_done      = done;
    assign busy         = running && (cls_q != CLS_READ);
    assign rdy_pull_low = busy;

    p_one_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_array |-> !$past(array_held));
    p_buf_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cmd_valid && (info.grp == GRP_BUFFER)
              && ((info.bufsel & held_buf) != 2'b00)) |-> !cmd_accept);
    p_buf_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(held_buf));
    p_buf_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !array_held |-> (held_buf == 2'b00));
    p_busy_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> array_held);
    p_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid && info.guarded && !wp_n && ({1'b0, cmd_page} < PROT_LIM))
        |-> !start_array);
    p_unknown_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cmd_valid && (info.grp == GRP_NONE)) |-> cmd_reject);
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_reject));
    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (!array_held && !cmd_accept && !cmd_reject && !err_flag));
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_flag) |-> err_flag);

endmodule

// File: tb/tb_fls_op_scheduler.sv
`timescale 1ns/1ps
module tb_fls_op_scheduler;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [7:0]  cmd_op;
    logic [10:0] cmd_page;
    logic        wp_n;
    logic        dur_we;
    logic [1:0]  dur_sel;
    logic [15:0] dur_val;
    logic        cmd_accept, cmd_reject, start_array, start_buffer;
    logic        array_held, busy, rdy_pull_low, err_flag, op_done;
    logic [1:0]  held_buf;

    int nchk  = 0;
    int nfail = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    fls_op_scheduler dut (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_page (cmd_page), .wp_n (wp_n), .dur_we (dur_we), .dur_sel (dur_sel),
        .dur_val (dur_val), .cmd_accept (cmd_accept), .cmd_reject (cmd_reject),
        .start_array (start_array), .start_buffer (start_buffer),
        .array_held (array_held), .busy (busy), .rdy_pull_low (rdy_pull_low),
        .err_flag (err_flag), .held_buf (held_buf), .op_done (op_done)
    );

    typedef struct packed {
        logic        wt;    // wait for an idle array first
        logic [7:0]  op;
        logic [10:0] pg;
        logic        wp;
        logic        acc;   // expected accept
        logic        bsy;   // expected busy
        logic        hld;   // expected array_held
        logic [1:0]  bsel;  // expected held_buf
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h53, 11'd5,    1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 4'd3},  // R3 transfer b1
        '{1'b0, 8'h84, 11'd0,    1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 4'd2},  // R2 held buffer write
        '{1'b0, 8'h87, 11'd0,    1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 4'd2},  // R2 other buffer write
        '{1'b0, 8'hD6, 11'd0,    1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 4'd2},  // R2 other buffer read
        '{1'b0, 8'h54, 11'd0,    1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 4'd2},  // R2 held buffer read
        '{1'b0, 8'hD7, 11'd0,    1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 4'd2},  // R2 status
        '{1'b0, 8'h81, 11'd300,  1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 4'd1},  // R1 second array op
        '{1'b1, 8'h52, 11'd3,    1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 4'd4},  // R4 page read no busy
        '{1'b0, 8'h84, 11'd0,    1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 4'd3},  // R3 no buffer held
        '{1'b0, 8'hD4, 11'd0,    1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 4'd3},  // R3
        '{1'b0, 8'h88, 11'd100,  1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 4'd1},  // R1
        '{1'b1, 8'h83, 11'd10,   1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd5},  // R5 protected
        '{1'b0, 8'h86, 11'd256,  1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 4'd5},  // R5 first free page
        '{1'b0, 8'h87, 11'd0,    1'b1, 1'b0, 1'b1, 1'b1, 2'b10, 4'd2},  // R2
        '{1'b0, 8'h84, 11'd0,    1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 4'd2},  // R2
        '{1'b0, 8'h55, 11'd7,    1'b1, 1'b0, 1'b1, 1'b1, 2'b10, 4'd1},  // R1
        '{1'b1, 8'h50, 11'd8,    1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd5},  // R5 block erase guarded
        '{1'b0, 8'h50, 11'd8,    1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 4'd5},  // R5 protection off
        '{1'b0, 8'h54, 11'd0,    1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 4'd3},  // R3 erase holds none
        '{1'b1, 8'h12, 11'd0,    1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 4'd6},  // R6 unknown
        '{1'b0, 8'h89, 11'd255,  1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd5},  // R5 last guarded page
        '{1'b0, 8'h58, 11'd255,  1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 4'd5},  // R5
        '{1'b1, 8'h61, 11'd0,    1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 4'd5},  // R5 compare unguarded
        '{1'b1, 8'h60, 11'd1,    1'b0, 1'b1, 1'b1, 1'b1, 2'b01, 4'd3},  // R3
        '{1'b1, 8'h82, 11'd2047, 1'b0, 1'b1, 1'b1, 1'b1, 2'b01, 4'd3},  // R3 top page
        '{1'b1, 8'h85, 11'd0,    1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 4'd5},  // R5
        '{1'b1, 8'h81, 11'd0,    1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'd5},  // R5 page erase guarded
        '{1'b0, 8'hE8, 11'd0,    1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 4'd6},  // R6 unsupported
        '{1'b0, 8'hD2, 11'd0,    1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 4'd4},  // R4
        '{1'b0, 8'h56, 11'd0,    1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 4'd2}   // R2
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic issue(input logic [7:0] op, input logic [10:0] pg, input logic wp);
        cmd_valid = 1'b1; cmd_op = op; cmd_page = pg; wp_n = wp;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [15:0] val);
        dur_we = 1'b1; dur_sel = sel; dur_val = val;
        @(negedge clk);
        dur_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300 && array_held; i++) @(negedge clk);
    endtask

    task automatic measure(output int len, output int done_at, output int npulse);
        len = 0; done_at = -1; npulse = 0;
        while (array_held && len < 300) begin
            if (op_done) begin done_at = len; npulse++; end
            @(negedge clk);
            len++;
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int len, dat, np;
        logic [6:0] act, exp;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 8'h00; cmd_page = '0;
        wp_n = 1'b1; dur_we = 1'b0; dur_sel = 2'd0; dur_val = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check({cmd_accept, cmd_reject, start_array, start_buffer, array_held, busy,
               rdy_pull_low, held_buf, op_done} == 10'd0, "R10 reset outputs",
              {cmd_accept, cmd_reject, array_held, busy}, 0);
        check(err_flag == 1'b0, "R11 err after reset", err_flag, 0);
        rst_n = 1'b1;
        step();

        // R7 response timing on a buffer command
        issue(8'h84, 11'd0, 1'b1);
        check(cmd_accept && !cmd_reject && start_buffer && !start_array, "R7 buffer start",
              {cmd_accept, start_buffer, start_array}, 6);
        step();
        check(!cmd_accept && !start_buffer, "R7 single pulse", {cmd_accept, start_buffer}, 0);

        // R8 duration and done position
        cfg(2'd1, 16'd4);
        issue(8'h53, 11'd9, 1'b1);
        check(start_array && cmd_accept, "R7 array start", start_array, 1);
        measure(len, dat, np);
        check(len == 4, "R8 held length", len, 4);
        check(dat == 3 && np == 1, "R8 done last cycle", dat, 3);
        check(held_buf == 2'b00, "R3 buffer released", held_buf, 0);

        // R8 zero duration acts as one
        cfg(2'd2, 16'd0);
        issue(8'h83, 11'd600, 1'b1);
        check(array_held && op_done, "R8 zero duration", {array_held, op_done}, 3);
        step();
        check(!array_held, "R8 zero duration ends", array_held, 0);

        // R12 command in the done cycle
        issue(8'h53, 11'd9, 1'b1);
        repeat (3) step();
        check(op_done == 1'b1, "R12 done cycle", op_done, 1);
        issue(8'h55, 11'd9, 1'b1);
        check(cmd_reject && !array_held, "R12 refused at done", {cmd_reject, array_held}, 2);
        issue(8'h55, 11'd9, 1'b1);
        check(cmd_accept && held_buf == 2'b10, "R12 next cycle accepted", held_buf, 2);
        wait_idle();

        // R9 load during an operation affects only later operations
        cfg(2'd3, 16'd6);
        issue(8'h81, 11'd900, 1'b1);
        cfg(2'd3, 16'd2);
        measure(len, dat, np);
        check(len == 5, "R9 running op keeps length", len + 1, 6);
        issue(8'h81, 11'd900, 1'b1);
        measure(len, dat, np);
        check(len == 2, "R9 new length used", len, 2);
        issue(8'h60, 11'd4, 1'b0);
        measure(len, dat, np);
        check(len == 4, "R9 other class unchanged", len, 4);

        // Vector walk with long durations
        for (int c = 0; c < 4; c++) cfg(2'(c), 16'd30);
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wt) wait_idle();
            issue(VEC[i].op, VEC[i].pg, VEC[i].wp);
            act = {cmd_accept, cmd_reject, busy, array_held, held_buf, rdy_pull_low};
            exp = {VEC[i].acc, !VEC[i].acc, VEC[i].bsy, VEC[i].hld, VEC[i].bsel, VEC[i].bsy};
            nchk++;
            if (act != exp) begin
                nfail++;
                $display("FAIL R%0d vector %0d: actual %b expected %b",
                         VEC[i].req, i, act, exp);
            end
        end

        // R11 sticky error
        check(err_flag == 1'b1, "R11 err set", err_flag, 1);
        wait_idle();
        issue(8'h57, 11'd0, 1'b1);
        check(err_flag == 1'b1, "R11 err holds", err_flag, 1);

        // R10 reset during an operation
        issue(8'h86, 11'd700, 1'b1);
        check(array_held == 1'b1, "R10 op running", array_held, 1);
        rst_n = 1'b0;
        cmd_valid = 1'b1; cmd_op = 8'h53; cmd_page = 11'd1; wp_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            check(!array_held && !busy && !cmd_accept && !cmd_reject && !err_flag,
                  "R10 idle in reset", {array_held, busy, cmd_accept, cmd_reject, err_flag}, 0);
        end
        cmd_valid = 1'b0;
        rst_n = 1'b1;
        step();
        issue(8'h81, 11'd500, 1'b1);
        check(cmd_accept == 1'b1, "R10 accept after reset", cmd_accept, 1);
        measure(len, dat, np);
        check(len == 12, "R10 default duration", len, 12);
        finish_run();
    end

endmodule